// File: doc/BRIEF.md
# Segment Descriptor Translation Unit

This block turns a segment-relative offset into a linear address. It holds four segment registers: code, data, stack and extra. Each one stores an index into a small on-chip table of descriptors. Each descriptor carries a base, a limit and a required privilege level.

For every request the unit picks a segment. The choice follows the kind of access, unless an explicit override names a register. The unit then reads that segment's descriptor and checks the offset against the limit and the caller's privilege against the descriptor. One cycle later it returns either base plus offset or a fault indication.

A flat mode treats every descriptor as base zero with an unbounded limit, but still applies the privilege check. Descriptors and segment registers are written through two separate load ports. Filling the table from memory is left to a surrounding block.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset every segment register holds index 0, every descriptor holds base 0, limit 0 and privilege level 0, and all response outputs are 0.
- R2: Without an override, the segment used follows `req_kind`. Kind 0 (fetch) uses the code register (segment number 0). Kind 1 (stack push or pop) uses the stack register (2). Kinds 2 and 3 (data) use the data register (1). The extra register (3) is never picked by default. The segment used is reported on `resp_seg`.
- R3: When `ovr_valid` is 1, the register numbered `ovr_sel` is used whatever `req_kind` is (0 code, 1 data, 2 stack, 3 extra).
- R4: The linear address is the descriptor base plus the zero-extended offset, taken modulo 2^LIN_W. For example, base 0x8000 with offset 0x2345 gives 0xA345.
- R5: `flt_limit` is 1 exactly when the offset is numerically greater than the descriptor limit. An offset equal to the limit is accepted.
- R6: `flt_priv` is 1 exactly when `cpl` is numerically greater than the descriptor privilege level (level 0 is the most privileged, 3 the least).
- R7: With `flat_mode` at 1, the base is taken as 0 and the limit as all ones. The linear address then equals the offset, no limit fault is raised, and the privilege check still applies.
- R8: Whenever either fault flag is 1, `resp_lin` is 0.
- R9: A request sampled with `req_valid` at 1 on a clock edge is answered on the outputs just after that edge with `resp_valid` at 1. After an edge with no request, all response outputs are 0.
- R10: A segment register write takes effect for requests on the following cycle. A request in the same cycle as the write still uses the old index.
- R11: A descriptor write takes effect for requests on the following cycle. A request in the same cycle as the write still sees the old descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sreg_we | input | 1 | Segment register write strobe |
| sreg_sel | input | 2 | Segment register to write (0 code, 1 data, 2 stack, 3 extra) |
| sreg_idx | input | IDX_W | Descriptor index to store |
| dt_we | input | 1 | Descriptor table write strobe |
| dt_idx | input | IDX_W | Descriptor entry to write |
| dt_base | input | LIN_W | Base to store |
| dt_limit | input | OFF_W | Limit to store |
| dt_dpl | input | 2 | Privilege level to store |
| flat_mode | input | 1 | Force base 0 and full limit |
| req_valid | input | 1 | Translation request |
| req_kind | input | 2 | Access kind (0 fetch, 1 stack, 2 or 3 data) |
| ovr_valid | input | 1 | Segment override present |
| ovr_sel | input | 2 | Override segment number |
| req_off | input | OFF_W | Segment-relative offset |
| cpl | input | 2 | Current privilege level |
| resp_valid | output | 1 | Response present |
| resp_lin | output | LIN_W | Linear address, 0 on a fault |
| resp_seg | output | 2 | Segment register that was used |
| flt_limit | output | 1 | Offset beyond limit |
| flt_priv | output | 2-level check failed, width 1 | Privilege fault |

## Verification
The main sweep loads all eight descriptors with distinct bases, limits and privilege levels. It rotates the segment registers through eight different mappings, so a wrong register or table index shows up as a wrong base. Every access kind and every override target is crossed with all four privilege levels, with flat mode on and off. The offsets used are zero, a mid value, exactly the limit, one past the limit and all ones, which separate an off-by-one limit compare and a missed carry from a correct one. Separate directed cases cover the reset contents, address wrap at the top of the linear space, and writes issued in the same cycle as a request, which separate next-cycle update from same-cycle bypass.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    SEG_CODE  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_EXTRA = 2'd3
  } seg_id_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_STACK = 2'd1,
    ACC_DATA  = 2'd2,
    ACC_DATA2 = 2'd3
  } acc_kind_e;

  // Segment chosen for an access: the override wins, else the kind decides.
  function automatic seg_id_e pick_segment(input logic [1:0] kind,
                                           input logic       ovr_on,
                                           input logic [1:0] ovr_seg);
    seg_id_e s;
    if (ovr_on) begin
      s = seg_id_e'(ovr_seg);
    end else begin
      case (acc_kind_e'(kind))
        ACC_FETCH: s = SEG_CODE;
        ACC_STACK: s = SEG_STACK;
        default:   s = SEG_DATA;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/seg_sel_regs.sv
module seg_sel_regs #(
  parameter int NSEG  = 4,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       rd_sel,
  output logic [IDX_W-1:0] rd_idx
);

  logic [IDX_W-1:0] idx_q [NSEG];

  for (genvar s = 0; s < NSEG; s++) begin : g_sreg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        idx_q[s] <= '0;
      end else if (wr_en && (wr_sel == 2'(s))) begin
        idx_q[s] <= wr_idx;
      end
    end
  end

  assign rd_idx = idx_q[rd_sel];

  a_r10_sreg_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> idx_q[$past(wr_sel)] == $past(wr_idx));

  a_r10_sreg_held: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(idx_q[0]) && $stable(idx_q[1]) && $stable(idx_q[2]) && $stable(idx_q[3]));

endmodule

// File: rtl/seg_desc_table.sv
module seg_desc_table #(
  parameter int NDESC = 8,
  parameter int OFF_W = 16,
  parameter int LIN_W = 24,
  localparam int IDX_W = $clog2(NDESC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [LIN_W-1:0] wr_base,
  input  logic [OFF_W-1:0] wr_limit,
  input  logic [1:0]       wr_dpl,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [LIN_W-1:0] rd_base,
  output logic [OFF_W-1:0] rd_limit,
  output logic [1:0]       rd_dpl
);

  logic [LIN_W-1:0] base_q  [NDESC];
  logic [OFF_W-1:0] limit_q [NDESC];
  logic [1:0]       dpl_q   [NDESC];

  for (genvar e = 0; e < NDESC; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[e]  <= '0;
        limit_q[e] <= '0;
        dpl_q[e]   <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(e))) begin
        base_q[e]  <= wr_base;
        limit_q[e] <= wr_limit;
        dpl_q[e]   <= wr_dpl;
      end
    end
  end

  always_comb begin
    rd_base  = base_q[rd_idx];
    rd_limit = limit_q[rd_idx];
    rd_dpl   = dpl_q[rd_idx];
  end

  a_r11_desc_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> base_q[$past(wr_idx)] == $past(wr_base)
           && limit_q[$past(wr_idx)] == $past(wr_limit)
           && dpl_q[$past(wr_idx)] == $past(wr_dpl));

endmodule

// File: rtl/seg_check.sv
module seg_check #(
  parameter int OFF_W = 16,
  parameter int LIN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       seg_in,
  input  logic [LIN_W-1:0] base,
  input  logic [OFF_W-1:0] limit,
  input  logic [1:0]       dpl,
  input  logic [OFF_W-1:0] off,
  input  logic [1:0]       cpl,
  input  logic             flat,
  output logic             resp_valid,
  output logic [LIN_W-1:0] resp_lin,
  output logic [1:0]       resp_seg,
  output logic             flt_limit,
  output logic             flt_priv
);

  function automatic logic [LIN_W-1:0] lin_sum(input logic [LIN_W-1:0] b,
                                               input logic [OFF_W-1:0] o);
    return b + LIN_W'(o);
  endfunction

  function automatic logic beyond_limit(input logic [OFF_W-1:0] o,
                                        input logic [OFF_W-1:0] lim);
    return o > lim;
  endfunction

  function automatic logic priv_denied(input logic [1:0] cur,
                                       input logic [1:0] need);
    return cur > need;
  endfunction

  logic [LIN_W-1:0] base_eff;
  logic [OFF_W-1:0] limit_eff;
  logic             hit_limit;
  logic             hit_priv;
  logic [LIN_W-1:0] lin_raw;

  always_comb begin
    base_eff  = flat ? '0 : base;
    limit_eff = flat ? '1 : limit;
    hit_limit = beyond_limit(off, limit_eff);
    hit_priv  = priv_denied(cpl, dpl);
    lin_raw   = lin_sum(base_eff, off);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !req_valid) begin
      resp_valid <= 1'b0;
      resp_lin   <= '0;
      resp_seg   <= '0;
      flt_limit  <= 1'b0;
      flt_priv   <= 1'b0;
    end else begin
      resp_valid <= 1'b1;
      resp_lin   <= (hit_limit || hit_priv) ? '0 : lin_raw;
      resp_seg   <= seg_in;
      flt_limit  <= hit_limit;
      flt_priv   <= hit_priv;
    end
  end

  a_r9_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid && resp_lin == '0 && !flt_limit && !flt_priv);

  a_r8_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_limit || flt_priv) |-> resp_lin == '0);

  a_r7_flat_no_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && flat) |=> !flt_limit);

  a_r6_ring0_allowed: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cpl == 2'd0) |=> !flt_priv);

  a_r5_zero_off_in_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && off == '0) |=> !flt_limit);

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int OFF_W = 16,
  parameter int LIN_W = 24,
  parameter int NDESC = 8,
  localparam int IDX_W = $clog2(NDESC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sreg_we,
  input  logic [1:0]       sreg_sel,
  input  logic [IDX_W-1:0] sreg_idx,
  input  logic             dt_we,
  input  logic [IDX_W-1:0] dt_idx,
  input  logic [LIN_W-1:0] dt_base,
  input  logic [OFF_W-1:0] dt_limit,
  input  logic [1:0]       dt_dpl,
  input  logic             flat_mode,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic             ovr_valid,
  input  logic [1:0]       ovr_sel,
  input  logic [OFF_W-1:0] req_off,
  input  logic [1:0]       cpl,
  output logic             resp_valid,
  output logic [LIN_W-1:0] resp_lin,
  output logic [1:0]       resp_seg,
  output logic             flt_limit,
  output logic             flt_priv
);

  seg_id_e          eff_seg;
  logic [IDX_W-1:0] eff_idx;
  logic [LIN_W-1:0] d_base;
  logic [OFF_W-1:0] d_limit;
  logic [1:0]       d_dpl;

  assign eff_seg = pick_segment(req_kind, ovr_valid, ovr_sel);

  seg_sel_regs #(.NSEG(4), .IDX_W(IDX_W)) u_sregs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (sreg_we),
    .wr_sel (sreg_sel),
    .wr_idx (sreg_idx),
    .rd_sel (eff_seg),
    .rd_idx (eff_idx)
  );

  seg_desc_table #(.NDESC(NDESC), .OFF_W(OFF_W), .LIN_W(LIN_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (dt_we),
    .wr_idx   (dt_idx),
    .wr_base  (dt_base),
    .wr_limit (dt_limit),
    .wr_dpl   (dt_dpl),
    .rd_idx   (eff_idx),
    .rd_base  (d_base),
    .rd_limit (d_limit),
    .rd_dpl   (d_dpl)
  );

  seg_check #(.OFF_W(OFF_W), .LIN_W(LIN_W)) u_check (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .seg_in     (eff_seg),
    .base       (d_base),
    .limit      (d_limit),
    .dpl        (d_dpl),
    .off        (req_off),
    .cpl        (cpl),
    .flat       (flat_mode),
    .resp_valid (resp_valid),
    .resp_lin   (resp_lin),
    .resp_seg   (resp_seg),
    .flt_limit  (flt_limit),
    .flt_priv   (flt_priv)
  );

  a_r3_override_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ovr_valid) |=> resp_seg == $past(ovr_sel));

  a_r2_fetch_uses_code: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ovr_valid && req_kind == 2'd0) |=> resp_seg == 2'd0);

  a_r2_no_default_extra: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ovr_valid) |=> resp_seg != 2'd3);

endmodule

// File: tb/seg_xlate_unit_test.sv
module seg_xlate_unit_test;

  localparam int OFF_W = 16;
  localparam int LIN_W = 24;
  localparam int NDESC = 8;
  localparam int IDX_W = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sreg_we = 1'b0;
  logic [1:0]       sreg_sel = '0;
  logic [IDX_W-1:0] sreg_idx = '0;
  logic             dt_we = 1'b0;
  logic [IDX_W-1:0] dt_idx = '0;
  logic [LIN_W-1:0] dt_base = '0;
  logic [OFF_W-1:0] dt_limit = '0;
  logic [1:0]       dt_dpl = '0;
  logic             flat_mode = 1'b0;
  logic             req_valid = 1'b0;
  logic [1:0]       req_kind = '0;
  logic             ovr_valid = 1'b0;
  logic [1:0]       ovr_sel = '0;
  logic [OFF_W-1:0] req_off = '0;
  logic [1:0]       cpl = '0;
  logic             resp_valid;
  logic [LIN_W-1:0] resp_lin;
  logic [1:0]       resp_seg;
  logic             flt_limit;
  logic             flt_priv;

  always #4 clk = ~clk;

  seg_xlate_unit #(.OFF_W(OFF_W), .LIN_W(LIN_W), .NDESC(NDESC)) uut (.*);

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [LIN_W-1:0] m_base [NDESC];
  logic [OFF_W-1:0] m_lim  [NDESC];
  logic [1:0]       m_dpl  [NDESC];
  logic [IDX_W-1:0] m_sreg [4];

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic put_desc(input int i, input logic [LIN_W-1:0] b,
                          input logic [OFF_W-1:0] l, input logic [1:0] d);
    @(negedge clk);
    dt_we = 1'b1; dt_idx = IDX_W'(i); dt_base = b; dt_limit = l; dt_dpl = d;
    @(negedge clk);
    dt_we = 1'b0;
    m_base[i] = b; m_lim[i] = l; m_dpl[i] = d;
  endtask

  task automatic put_sreg(input int s, input int idx);
    @(negedge clk);
    sreg_we = 1'b1; sreg_sel = 2'(s); sreg_idx = IDX_W'(idx);
    @(negedge clk);
    sreg_we = 1'b0;
    m_sreg[s] = IDX_W'(idx);
  endtask

  // Drive one request, check the response one edge later against the model.
  task automatic request(input logic [1:0] kind, input logic ov, input logic [1:0] os,
                         input logic [OFF_W-1:0] off, input logic [1:0] lvl,
                         input logic fl);
    logic [1:0]       seg;
    logic [IDX_W-1:0] ix;
    logic             e_lim, e_prv;
    logic [LIN_W-1:0] e_lin;
    string            lin_tag;
    seg = ov ? os : (kind == 2'd0 ? 2'd0 : (kind == 2'd1 ? 2'd2 : 2'd1));
    ix = m_sreg[seg];
    e_lim = fl ? 1'b0 : (off > m_lim[ix]);
    e_prv = lvl > m_dpl[ix];
    e_lin = fl ? LIN_W'(off) : LIN_W'(m_base[ix] + LIN_W'(off));
    if (e_lim || e_prv) e_lin = '0;
    lin_tag = (e_lim || e_prv) ? "R8" : (fl ? "R7" : "R4");
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; ovr_valid = ov; ovr_sel = os;
    req_off = off; cpl = lvl; flat_mode = fl;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9", "resp_valid", 32'(resp_valid), 32'd1);
    chk(ov ? "R3" : "R2", "resp_seg", 32'(resp_seg), 32'(seg));
    chk(fl ? "R7" : "R5", "flt_limit", 32'(flt_limit), 32'(e_lim));
    chk("R6", "flt_priv", 32'(flt_priv), 32'(e_prv));
    chk(lin_tag, "resp_lin", 32'(resp_lin), 32'(e_lin));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NDESC; i++) begin
      m_base[i] = '0; m_lim[i] = '0; m_dpl[i] = '0;
    end
    for (int s = 0; s < 4; s++) m_sreg[s] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: outputs quiet, table and registers cleared
    chk("R1", "resp_valid", 32'(resp_valid), 32'd0);
    chk("R1", "resp_lin", 32'(resp_lin), 32'd0);
    chk("R1", "flt_limit", 32'(flt_limit), 32'd0);
    chk("R1", "flt_priv", 32'(flt_priv), 32'd0);
    request(2'd0, 1'b0, 2'd0, 16'h0000, 2'd0, 1'b0);   // R1 limit 0 accepts offset 0
    request(2'd0, 1'b0, 2'd0, 16'h0001, 2'd0, 1'b0);   // R1 limit 0 rejects offset 1
    request(2'd2, 1'b1, 2'd3, 16'h0000, 2'd1, 1'b0);   // R1 dpl 0 rejects cpl 1
    // R9: idle cycle leaves outputs zero
    @(negedge clk);
    chk("R9", "idle resp_valid", 32'(resp_valid), 32'd0);

    // Load the table with distinct entries
    for (int i = 0; i < NDESC; i++)
      put_desc(i, LIN_W'(24'h8000 + i * 24'h1F000), OFF_W'(16'h3FFF + i * 16'h1800), 2'(i % 4));
    put_desc(7, 24'hFFF000, 16'hFFFF, 2'd3);
    put_desc(0, 24'h008000, 16'h3FFF, 2'd3);

    // R4: worked example, base 0x8000 plus 0x2345
    for (int s = 0; s < 4; s++) put_sreg(s, 0);
    request(2'd2, 1'b0, 2'd0, 16'h2345, 2'd3, 1'b0);
    chk("R4", "example lin", 32'(resp_lin), 32'h00A345);
    // R4: wrap at top of linear space
    put_sreg(3, 7);
    request(2'd0, 1'b1, 2'd3, 16'h2000, 2'd0, 1'b0);
    chk("R4", "wrap lin", 32'(resp_lin), 32'h001000);

    // R10: segment write and request in the same cycle
    @(negedge clk);
    sreg_we = 1'b1; sreg_sel = 2'd0; sreg_idx = 3'd5;
    req_valid = 1'b1; req_kind = 2'd0; ovr_valid = 1'b0; req_off = 16'h0010;
    cpl = 2'd0; flat_mode = 1'b0;
    @(negedge clk);
    sreg_we = 1'b0; req_valid = 1'b0;
    chk("R10", "same-cycle old index", 32'(resp_lin), 32'(m_base[0] + 24'h10));
    m_sreg[0] = 3'd5;
    request(2'd0, 1'b0, 2'd0, 16'h0010, 2'd0, 1'b0);
    chk("R10", "next-cycle new index", 32'(resp_lin), 32'(m_base[5] + 24'h10));

    // R11: descriptor write and request in the same cycle
    @(negedge clk);
    dt_we = 1'b1; dt_idx = 3'd5; dt_base = 24'h400000; dt_limit = 16'h00FF; dt_dpl = 2'd3;
    req_valid = 1'b1; req_kind = 2'd0; ovr_valid = 1'b0; req_off = 16'h0020; cpl = 2'd0;
    @(negedge clk);
    dt_we = 1'b0; req_valid = 1'b0;
    chk("R11", "same-cycle old base", 32'(resp_lin), 32'(m_base[5] + 24'h20));
    m_base[5] = 24'h400000; m_lim[5] = 16'h00FF; m_dpl[5] = 2'd3;
    request(2'd0, 1'b0, 2'd0, 16'h0020, 2'd0, 1'b0);
    chk("R11", "next-cycle new base", 32'(resp_lin), 32'h400020);

    // Main sweep: mappings x selection x privilege x offsets x flat
    for (int p = 0; p < 8; p++) begin
      for (int s = 0; s < 4; s++) put_sreg(s, (p + s * 3) % 8);
      for (int m = 0; m < 8; m++) begin
        for (int lv = 0; lv < 4; lv++) begin
          for (int fl = 0; fl < 2; fl++) begin
            logic [1:0]       k;
            logic             ov;
            logic [1:0]       seg;
            logic [OFF_W-1:0] lim;
            k   = 2'(m % 4);
            ov  = (m >= 4);
            seg = ov ? k : (k == 2'd0 ? 2'd0 : (k == 2'd1 ? 2'd2 : 2'd1));
            lim = m_lim[m_sreg[seg]];
            request(k, ov, k, 16'h0000, 2'(lv), fl[0]);
            request(k, ov, k, 16'h2345, 2'(lv), fl[0]);
            request(k, ov, k, lim, 2'(lv), fl[0]);
            request(k, ov, k, lim + 16'h1, 2'(lv), fl[0]);
            request(k, ov, k, 16'hFFFF, 2'(lv), fl[0]);
          end
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule